// File: doc/BRIEF.md
# Stage Register with Hold, Flush and Conflict Trapping

This block is one inter-stage register of an in-order pipeline. It carries a bundle made of a payload word and a 3-bit status code from one stage to the next. In every cycle an external hazard unit drives two requests. A freeze request keeps the current contents. A flush request replaces the contents with a fixed empty-slot pattern. When neither request is raised, the register takes the upstream bundle.

If both requests are raised in the same cycle, the hazard unit has failed. The register does not pick either action. It loads the empty-slot payload with the status forced to a pipe-error code. It also sets a sticky trap flag. While the flag is set, every later clock edge loads the same error slot, whatever the requests are. Only a synchronous reset clears the flag. Reset also fills the register with the empty-slot pattern.

The empty-slot payload is a parameter. For a typical stage it holds a no-op operation code, "no register" selectors and zero data words. Status codes are: empty slot 0, OK 1, halt 2, bad address 3, bad operation 4, pipe error 5.

Top module: `pipe_stage_reg`

## Requirements
- R1: While reset is high at a rising edge, the next outputs are the empty-slot payload, status 0 and trap flag 0.
- R2: If neither request is high at an edge and the trap flag is clear, the payload and status inputs appear on the outputs after that edge.
- R3: If only the freeze request is high at an edge and the trap flag is clear, the payload and status outputs keep their values, whatever the inputs are.
- R4: If only the flush request is high at an edge and the trap flag is clear, the outputs become the empty-slot payload with status 0.
- R5: If both requests are high at an edge, the outputs after that edge are the empty-slot payload with status 5, and the trap flag is 1.
- R6: Once the trap flag is set, every following edge without reset keeps the flag at 1 and gives the empty-slot payload with status 5, for any request or input pattern.
- R7: A reset after a trap clears the flag, and normal loading (R2) works again from the next edge.
- R8: In a load, every 3-bit status value is passed on unchanged, including 5 and the unused codes 6 and 7. Only the trap sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| hold_req | input | 1 | Freeze request from the hazard unit |
| flush_req | input | 1 | Flush (empty-slot) request from the hazard unit |
| pay_i | input | PAY_W | Upstream payload |
| stat_i | input | 3 | Upstream status code |
| pay_o | output | PAY_W | Stored payload |
| stat_o | output | 3 | Stored status code |
| trap_o | output | 1 | Sticky request-conflict flag |

## Verification
The bench uses an 8-bit payload. Every payload value is applied under plain load, under freeze and under flush. The status input is varied over all eight codes, so the test can tell a correct capture from a stale hold or a wrong empty-slot load. A status of 5 that arrives through a normal load shows that the flag is raised only by a real conflict. After a conflict, every request combination is tried with changing inputs, to show that the trap stays in place. A reset is then applied, followed by fresh loads, to show that the trap is released.

// File: rtl/pipe_stage_pkg.sv
package pipe_stage_pkg;

    localparam int STAT_W = 3;

    localparam logic [STAT_W-1:0] ST_EMPTY = 3'd0;
    localparam logic [STAT_W-1:0] ST_OK    = 3'd1;
    localparam logic [STAT_W-1:0] ST_HALT  = 3'd2;
    localparam logic [STAT_W-1:0] ST_BADA  = 3'd3;
    localparam logic [STAT_W-1:0] ST_BADOP = 3'd4;
    localparam logic [STAT_W-1:0] ST_PERR  = 3'd5;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_HOLD  = 2'd1,
        OP_FLUSH = 2'd2,
        OP_TRAP  = 2'd3
    } stage_op_e;

endpackage

// File: rtl/stage_op_sel.sv
module stage_op_sel
    import pipe_stage_pkg::*;
(
    input  logic      hold_req,
    input  logic      flush_req,
    input  logic      trap_q,
    output stage_op_e op
);
    always_comb begin
        if (trap_q || (hold_req && flush_req)) begin
            op = OP_TRAP;
        end else if (hold_req) begin
            op = OP_HOLD;
        end else if (flush_req) begin
            op = OP_FLUSH;
        end else begin
            op = OP_LOAD;
        end
    end
endmodule

// File: rtl/stage_next_mux.sv
module stage_next_mux
    import pipe_stage_pkg::*;
#(
    parameter int               PAY_W      = 16,
    parameter logic [PAY_W-1:0] BUBBLE_PAY = '0
) (
    input  stage_op_e         op,
    input  logic [PAY_W-1:0]  cur_pay,
    input  logic [STAT_W-1:0] cur_stat,
    input  logic [PAY_W-1:0]  new_pay,
    input  logic [STAT_W-1:0] new_stat,
    output logic [PAY_W-1:0]  nxt_pay,
    output logic [STAT_W-1:0] nxt_stat
);
    always_comb begin
        unique case (op)
            OP_HOLD: begin
                nxt_pay  = cur_pay;
                nxt_stat = cur_stat;
            end
            OP_FLUSH: begin
                nxt_pay  = BUBBLE_PAY;
                nxt_stat = ST_EMPTY;
            end
            OP_TRAP: begin
                nxt_pay  = BUBBLE_PAY;
                nxt_stat = ST_PERR;
            end
            default: begin
                nxt_pay  = new_pay;
                nxt_stat = new_stat;
            end
        endcase
    end
endmodule

// File: rtl/pipe_stage_reg.sv
module pipe_stage_reg
    import pipe_stage_pkg::*;
#(
    parameter int               PAY_W      = 16,
    parameter logic [PAY_W-1:0] BUBBLE_PAY = 16'h1FF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_req,
    input  logic              flush_req,
    input  logic [PAY_W-1:0]  pay_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic [PAY_W-1:0]  pay_o,
    output logic [STAT_W-1:0] stat_o,
    output logic              trap_o
);
    typedef struct packed {
        logic [PAY_W-1:0]  pay;
        logic [STAT_W-1:0] stat;
        logic              trap;
    } slot_t;

    slot_t             slot_d, slot_q;
    stage_op_e         op;
    logic [PAY_W-1:0]  mux_pay;
    logic [STAT_W-1:0] mux_stat;

    stage_op_sel u_sel (
        .hold_req (hold_req),
        .flush_req(flush_req),
        .trap_q   (slot_q.trap),
        .op       (op)
    );

    stage_next_mux #(
        .PAY_W     (PAY_W),
        .BUBBLE_PAY(BUBBLE_PAY)
    ) u_mux (
        .op      (op),
        .cur_pay (slot_q.pay),
        .cur_stat(slot_q.stat),
        .new_pay (pay_i),
        .new_stat(stat_i),
        .nxt_pay (mux_pay),
        .nxt_stat(mux_stat)
    );

    always_comb begin
        slot_d.pay  = mux_pay;
        slot_d.stat = mux_stat;
        slot_d.trap = (op == OP_TRAP);
        if (rst) begin
            slot_d.pay  = BUBBLE_PAY;
            slot_d.stat = ST_EMPTY;
            slot_d.trap = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        slot_q <= slot_d;
    end

    assign pay_o  = slot_q.pay;
    assign stat_o = slot_q.stat;
    assign trap_o = slot_q.trap;
endmodule

// File: rtl/pipe_stage_reg_chk.sv
module pipe_stage_reg_chk
    import pipe_stage_pkg::*;
#(
    parameter int               PAY_W      = 16,
    parameter logic [PAY_W-1:0] BUBBLE_PAY = 16'h1FF0
) (
    input logic              clk,
    input logic              rst,
    input logic              hold_req,
    input logic              flush_req,
    input logic [PAY_W-1:0]  pay_i,
    input logic [STAT_W-1:0] stat_i,
    input logic [PAY_W-1:0]  pay_o,
    input logic [STAT_W-1:0] stat_o,
    input logic              trap_o
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (pay_o == BUBBLE_PAY && stat_o == ST_EMPTY && !trap_o));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!hold_req && !flush_req && !trap_o)
        |=> (pay_o == $past(pay_i) && stat_o == $past(stat_i)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (hold_req && !flush_req && !trap_o) |=> ($stable(pay_o) && $stable(stat_o)));

    p_flush_r4: assert property (@(posedge clk) disable iff (rst)
        (flush_req && !hold_req && !trap_o)
        |=> (pay_o == BUBBLE_PAY && stat_o == ST_EMPTY && !trap_o));

    p_conflict_r5: assert property (@(posedge clk) disable iff (rst)
        (hold_req && flush_req) |=> (trap_o && stat_o == ST_PERR && pay_o == BUBBLE_PAY));

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        trap_o |=> (trap_o && stat_o == ST_PERR));

    p_flag_src_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(trap_o) |-> $past(hold_req && flush_req));
endmodule

bind pipe_stage_reg pipe_stage_reg_chk #(
    .PAY_W     (PAY_W),
    .BUBBLE_PAY(BUBBLE_PAY)
) u_chk (.*);

// File: tb/pipe_stage_reg_bench.sv
`timescale 1ns/1ps
module pipe_stage_reg_bench;
    localparam int         PW  = 8;
    localparam logic [7:0] BUB = 8'hA5;

    logic       clk = 1'b0;
    logic       rst, hold_req, flush_req, trap_o;
    logic [7:0] pay_i, pay_o;
    logic [2:0] stat_i, stat_o;

    logic [7:0] e_pay;
    logic [2:0] e_stat;
    logic       e_trap;
    int vecs = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pipe_stage_reg #(.PAY_W(PW), .BUBBLE_PAY(BUB)) u_pipe_stage_reg (
        .clk(clk), .rst(rst), .hold_req(hold_req), .flush_req(flush_req),
        .pay_i(pay_i), .stat_i(stat_i), .pay_o(pay_o), .stat_o(stat_o),
        .trap_o(trap_o)
    );

    task automatic check(input string tag);
        vecs++;
        if (pay_o !== e_pay || stat_o !== e_stat || trap_o !== e_trap) begin
            bad++;
            $display("FAIL %s: got pay=%h stat=%0d trap=%0b, expected pay=%h stat=%0d trap=%0b",
                     tag, pay_o, stat_o, trap_o, e_pay, e_stat, e_trap);
        end
    endtask

    task automatic step(input logic r, input logic h, input logic f,
                        input logic [7:0] p, input logic [2:0] s, input string tag);
        rst = r; hold_req = h; flush_req = f; pay_i = p; stat_i = s;
        @(posedge clk);
        if (r) begin
            e_pay = BUB; e_stat = 3'd0; e_trap = 1'b0;
        end else if (e_trap || (h && f)) begin
            e_pay = BUB; e_stat = 3'd5; e_trap = 1'b1;
        end else if (h) begin
            e_pay = e_pay;
        end else if (f) begin
            e_pay = BUB; e_stat = 3'd0;
        end else begin
            e_pay = p; e_stat = s;
        end
        #1 check(tag);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    initial begin
        e_pay = BUB; e_stat = 3'd0; e_trap = 1'b0;
        @(negedge clk);
        step(1, 0, 0, 8'h00, 3'd1, "R1");
        step(1, 1, 1, 8'h3C, 3'd2, "R1");
        // exhaustive payload sweep under load, freeze and flush
        for (int p = 0; p < 256; p++) begin
            step(0, 0, 0, p[7:0], p[2:0], "R2");
            step(0, 1, 0, ~p[7:0], p[5:3], "R3");
            step(0, 0, 1, p[7:0] ^ 8'h5A, 3'd1, "R4");
        end
        // every status code passes through a load, no trap from code 5
        for (int s = 0; s < 8; s++) begin
            step(0, 0, 0, 8'h10 + s[7:0], s[2:0], "R8");
        end
        // conflict then sticky trap under every request pattern
        step(0, 1, 1, 8'h77, 3'd1, "R5");
        for (int k = 0; k < 32; k++) begin
            step(0, k[0], k[1], k[7:0] * 8'd7, k[2:0], "R6");
        end
        // reset releases trap
        step(1, 0, 0, 8'h00, 3'd0, "R7");
        for (int k = 0; k < 8; k++) begin
            step(0, 0, 0, 8'hC0 | k[7:0], k[2:0], "R7");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule